// File: doc/BRIEF.md
# Serial Command and RAM Write Interface

This block accepts a write-only three-wire serial link (active-low select, shift clock and data) and turns it into write strobes for a display controller. Each serial byte is shifted in least significant bit first. Once the eighth bit arrives, the byte is used automatically, with no external latch signal. Framing restarts every time the select line goes low.

The first byte of a transfer holds a 3-bit command and a 5-bit start address. A RAM command steers every later byte of that transfer to one of four RAM targets, at an address that steps up by one after each byte and wraps within 32 locations. A register command takes exactly one value byte, and any bytes after it are ignored.

The serial signals are brought into the system clock domain through a two-flop synchroniser with edge detection. The system clock must run at least four times faster than the shift clock.

Top module: `serw_top`

## Requirements
- R1: While cs_n is high, shift clock edges and data are ignored: no bit is counted and no strobe is produced.
- R2: sdata is sampled on the rising edge of sclk, and sclk runs at no more than a quarter of the clk frequency.
- R3: Each byte arrives least significant bit first: the first bit after cs_n falls is bit 0 of the byte.
- R4: After the eighth bit of a byte, the byte is acted on automatically, with no further input. Its strobe appears no more than 10 clk cycles after that eighth rising sclk edge.
- R5: A falling edge of cs_n clears the bit count to zero and discards any partial byte.
- R6: The first byte of a transfer is decoded with bits [7:5] as the command and bits [4:0] as the start address. Commands 0, 1, 2 and 3 select RAM targets 0 (character), 1 (attribute), 2 (glyph) and 3 (graphics), reported on ram_sel. Commands 4 to 7 are register writes whose reg_code is command bits [1:0]. The command byte itself raises no strobe.
- R7: In a RAM transfer, data byte k (counting from 0) is written to the start address plus k.
- R8: The RAM address is 5 bits wide and wraps from 31 to 0.
- R9: A register command writes the next byte to reg_code/reg_addr. Any further bytes in that transfer produce no strobe.
- R10: ram_we and reg_we are single-cycle pulses, never high together, with at most one pulse per data byte.
- R11: After reset, both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial shift clock |
| sdata | input | 1 | Serial data, LSB first |
| ram_we | output | 1 | RAM write strobe |
| ram_sel | output | 2 | RAM target code |
| ram_addr | output | 5 | RAM write address |
| ram_data | output | 8 | RAM write data |
| reg_we | output | 1 | Register write strobe |
| reg_code | output | 2 | Register command code |
| reg_addr | output | 5 | Register address |
| reg_data | output | 8 | Register write data |

## Verification
A vector table of complete transfers covers every command code. Each RAM command is given several data bytes, which separates correct per-byte address stepping from a stuck address, and start addresses of 30 and 31 separate a 5-bit wrap from a carry into a wider field. Register commands are sent with one, two and three value bytes, and a command byte with no data is also sent; together these show that exactly one write follows a register command and that a command byte writes nothing. Directed transfers then toggle sclk with the select high and abort a partial byte, each followed by a clean transfer whose logged address and data show whether stray bits were counted.

// File: rtl/serw_pkg.sv
package serw_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 5;
  localparam int CMD_W  = DATA_W - ADDR_W;
  localparam int SEL_W  = 2;

  typedef enum logic [SEL_W-1:0] {
    TGT_CHAR  = 2'd0,
    TGT_ATTR  = 2'd1,
    TGT_GLYPH = 2'd2,
    TGT_GFX   = 2'd3
  } ram_tgt_e;

  // command MSB clear selects a RAM target
  function automatic logic cmd_is_ram(input logic [CMD_W-1:0] c);
    return ~c[CMD_W-1];
  endfunction

  function automatic logic [SEL_W-1:0] cmd_sel(input logic [CMD_W-1:0] c);
    return c[SEL_W-1:0];
  endfunction

  // address advance with natural wrap of the ADDR_W-bit field
  function automatic logic [ADDR_W-1:0] addr_step(input logic [ADDR_W-1:0] a);
    return a + {{(ADDR_W-1){1'b0}}, 1'b1};
  endfunction
endpackage

// File: rtl/serw_sync.sv
module serw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic sdata,
  output logic cs_act,
  output logic cs_fall,
  output logic sclk_rise,
  output logic bit_val
);
  logic [STAGES:0]   cs_p;
  logic [STAGES:0]   sclk_p;
  logic [STAGES-1:0] dat_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_p   <= '1;
      sclk_p <= '0;
      dat_p  <= '0;
    end else begin
      cs_p   <= {cs_p[STAGES-1:0], cs_n};
      sclk_p <= {sclk_p[STAGES-1:0], sclk};
      dat_p  <= {dat_p[STAGES-2:0], sdata};
    end
  end

  // synchronised level at index STAGES-1, one-cycle-older copy at STAGES
  assign cs_act    = ~cs_p[STAGES-1];
  assign cs_fall   = ~cs_p[STAGES-1] & cs_p[STAGES];
  assign sclk_rise = sclk_p[STAGES-1] & ~sclk_p[STAGES];
  assign bit_val   = dat_p[STAGES-1];
endmodule

// File: rtl/serw_deframe.sv
module serw_deframe #(
  parameter int DATA_W = serw_pkg::DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              cs_fall,
  input  logic              sclk_rise,
  input  logic              bit_val,
  output logic              byte_stb,
  output logic              byte_first,
  output logic [DATA_W-1:0] byte_q
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] shreg;
  logic              first_pend;
  logic [DATA_W-1:0] shifted;
  logic              take_bit;

  assign take_bit = sclk_rise & cs_act;
  // LSB first: new bits enter at the top and move down toward bit 0
  assign shifted  = {bit_val, shreg[DATA_W-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt    <= '0;
      shreg      <= '0;
      first_pend <= 1'b0;
      byte_stb   <= 1'b0;
      byte_first <= 1'b0;
      byte_q     <= '0;
    end else begin
      byte_stb <= 1'b0;
      if (cs_fall) begin
        bit_cnt    <= '0;
        shreg      <= '0;
        first_pend <= 1'b1;
      end else if (take_bit) begin
        shreg <= shifted;
        if (bit_cnt == LAST) begin
          bit_cnt    <= '0;
          byte_stb   <= 1'b1;
          byte_q     <= shifted;
          byte_first <= first_pend;
          first_pend <= 1'b0;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  AST_FRAME_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> (bit_cnt == '0) && !byte_stb); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !byte_stb); // R1
endmodule

// File: rtl/serw_decode.sv
module serw_decode
  import serw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_fall,
  input  logic              byte_stb,
  input  logic              byte_first,
  input  logic [DATA_W-1:0] byte_q,
  output logic              ram_we,
  output logic [SEL_W-1:0]  ram_sel,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_data,
  output logic              reg_we,
  output logic [SEL_W-1:0]  reg_code,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_data
);
  logic [CMD_W-1:0]  cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic              active_q;
  logic              reg_done_q;
  logic              cmd_load;
  logic              data_byte;

  assign cmd_load  = byte_stb & byte_first;
  assign data_byte = byte_stb & ~byte_first & active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q      <= '0;
      addr_q     <= '0;
      active_q   <= 1'b0;
      reg_done_q <= 1'b0;
      ram_we     <= 1'b0;
      ram_sel    <= '0;
      ram_addr   <= '0;
      ram_data   <= '0;
      reg_we     <= 1'b0;
      reg_code   <= '0;
      reg_addr   <= '0;
      reg_data   <= '0;
    end else begin
      ram_we <= 1'b0;
      reg_we <= 1'b0;
      if (cs_fall) begin
        active_q <= 1'b0;
      end else if (cmd_load) begin
        cmd_q      <= byte_q[DATA_W-1:ADDR_W];
        addr_q     <= byte_q[ADDR_W-1:0];
        active_q   <= 1'b1;
        reg_done_q <= 1'b0;
      end else if (data_byte) begin
        if (cmd_is_ram(cmd_q)) begin
          ram_we   <= 1'b1;
          ram_sel  <= cmd_sel(cmd_q);
          ram_addr <= addr_q;
          ram_data <= byte_q;
          addr_q   <= addr_step(addr_q);
        end else if (!reg_done_q) begin
          reg_we     <= 1'b1;
          reg_code   <= cmd_sel(cmd_q);
          reg_addr   <= addr_q;
          reg_data   <= byte_q;
          reg_done_q <= 1'b1;
        end
      end
    end
  end

  // checker state, independent of the write path above
  logic              chk_have_prev;
  logic [ADDR_W-1:0] chk_prev;
  logic              chk_reg_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_have_prev <= 1'b0;
      chk_prev      <= '0;
      chk_reg_seen  <= 1'b0;
    end else if (cmd_load) begin
      chk_have_prev <= 1'b0;
      chk_reg_seen  <= 1'b0;
    end else begin
      if (ram_we) begin
        chk_have_prev <= 1'b1;
        chk_prev      <= ram_addr;
      end
      if (reg_we) chk_reg_seen <= 1'b1;
    end
  end

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we && chk_have_prev |-> ram_addr == addr_step(chk_prev)); // R7
  AST_REG_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> !chk_reg_seen); // R9
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_we && reg_we)); // R10
  AST_RAM_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |=> !ram_we); // R10
  AST_REG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we); // R10
  AST_CMD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_load |=> !ram_we && !reg_we); // R6
endmodule

// File: rtl/serw_top.sv
module serw_top
  import serw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdata,
  output logic              ram_we,
  output logic [SEL_W-1:0]  ram_sel,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_data,
  output logic              reg_we,
  output logic [SEL_W-1:0]  reg_code,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_data
);
  logic              cs_act;
  logic              cs_fall;
  logic              sclk_rise;
  logic              bit_val;
  logic              byte_stb;
  logic              byte_first;
  logic [DATA_W-1:0] byte_q;

  serw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdata(sdata),
    .cs_act(cs_act), .cs_fall(cs_fall), .sclk_rise(sclk_rise), .bit_val(bit_val)
  );

  serw_deframe #(.DATA_W(DATA_W)) u_deframe (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .cs_fall(cs_fall),
    .sclk_rise(sclk_rise), .bit_val(bit_val),
    .byte_stb(byte_stb), .byte_first(byte_first), .byte_q(byte_q)
  );

  serw_decode u_decode (
    .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall),
    .byte_stb(byte_stb), .byte_first(byte_first), .byte_q(byte_q),
    .ram_we(ram_we), .ram_sel(ram_sel), .ram_addr(ram_addr), .ram_data(ram_data),
    .reg_we(reg_we), .reg_code(reg_code), .reg_addr(reg_addr), .reg_data(reg_data)
  );
endmodule

// File: tb/sim_serw_top.sv
`timescale 1ns/1ps
module sim_serw_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdata = 1'b0;
  logic       ram_we, reg_we;
  logic [1:0] ram_sel, reg_code;
  logic [4:0] ram_addr, reg_addr;
  logic [7:0] ram_data, reg_data;

  always #2 clk = ~clk;

  serw_top u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdata(sdata),
    .ram_we(ram_we), .ram_sel(ram_sel), .ram_addr(ram_addr), .ram_data(ram_data),
    .reg_we(reg_we), .reg_code(reg_code), .reg_addr(reg_addr), .reg_data(reg_data)
  );

  int errors = 0, checks = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // write log: kind 0 = RAM, 1 = register
  int       log_n = 0;
  bit       log_kind [32];
  int       log_sel  [32];
  int       log_addr [32];
  int       log_data [32];
  int       pulse_err = 0, both_err = 0;
  logic     prev_ram = 1'b0, prev_reg = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (ram_we && reg_we) both_err++;
      if ((ram_we && prev_ram) || (reg_we && prev_reg)) pulse_err++;
      if ((ram_we || reg_we) && log_n < 32) begin
        log_kind[log_n] = reg_we;
        log_sel[log_n]  = reg_we ? int'(reg_code) : int'(ram_sel);
        log_addr[log_n] = reg_we ? int'(reg_addr) : int'(ram_addr);
        log_data[log_n] = reg_we ? int'(reg_data) : int'(ram_data);
        log_n++;
      end
    end
    prev_ram = ram_we;
    prev_reg = reg_we;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_bit(input bit b);
    sdata = b; tick(5);
    sclk = 1'b1; tick(5);
    sclk = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) send_bit(b[i]);
  endtask

  task automatic start_xfer();
    cs_n = 1'b0; tick(6);
  endtask

  task automatic stop_xfer();
    tick(12); cs_n = 1'b1; tick(8);
  endtask

  function automatic logic [7:0] dbyte(input logic [7:0] seed, input int i);
    return seed + 8'(i * 29);
  endfunction

  // {command byte, data byte count, seed}
  localparam int NV = 8;
  localparam logic [19:0] VEC [NV] = '{
    {8'h03, 4'd4, 8'h41},  // char RAM, addr 3
    {8'h3E, 4'd4, 8'h92},  // attr RAM, addr 30, wraps (R8)
    {8'h45, 4'd3, 8'hA6},  // glyph RAM, addr 5
    {8'h7F, 4'd2, 8'h1C},  // graphics RAM, addr 31, wraps (R8)
    {8'h8A, 4'd3, 8'h5B},  // register code 0, extra bytes ignored (R9)
    {8'hF1, 4'd1, 8'hE7},  // register code 3
    {8'h20, 4'd0, 8'h00},  // command only, nothing written (R6)
    {8'hC7, 4'd2, 8'h38}   // register code 2
  };

  initial begin
    #600000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(4);
    chk(ram_we == 1'b0 && reg_we == 1'b0, "R11", "strobes in reset", {ram_we, reg_we}, 0);
    rst_n = 1'b1; tick(4);
    chk(ram_we == 1'b0 && reg_we == 1'b0, "R11", "strobes after reset", {ram_we, reg_we}, 0);

    for (int v = 0; v < NV; v++) begin
      logic [7:0] cb; int cnt; logic [7:0] sd; int exp_n; bit isram;
      cb = VEC[v][19:12]; cnt = int'(VEC[v][11:8]); sd = VEC[v][7:0];
      isram = ~cb[7];
      exp_n = isram ? cnt : (cnt > 0 ? 1 : 0);
      log_n = 0;
      start_xfer();
      send_byte(cb);
      for (int i = 0; i < cnt; i++) send_byte(dbyte(sd, i));
      stop_xfer();
      chk(log_n == exp_n, isram ? "R7" : "R9", $sformatf("write count vec %0d", v), log_n, exp_n);
      for (int i = 0; i < exp_n && i < log_n; i++) begin
        int ea; ea = (int'(cb[4:0]) + (isram ? i : 0)) % 32;
        chk(log_kind[i] == !isram, "R6", "write kind", int'(log_kind[i]), int'(!isram));
        chk(log_sel[i] == int'(cb[6:5]) || (!isram && log_sel[i] == int'(cb[6:5])),
            "R6", "select code", log_sel[i], int'(cb[6:5]));
        chk(log_addr[i] == ea, "R8", $sformatf("address vec %0d byte %0d", v, i), log_addr[i], ea);
        chk(log_data[i] == int'(dbyte(sd, i)), "R3", "data byte LSB first",
            log_data[i], int'(dbyte(sd, i)));
      end
    end

    // R1: clocks with select high are ignored, then a clean transfer frames correctly
    log_n = 0;
    for (int i = 0; i < 11; i++) send_bit(i[0]);
    tick(10);
    chk(log_n == 0, "R1", "writes while deselected", log_n, 0);
    start_xfer(); send_byte(8'h05); send_byte(8'h5A); stop_xfer();
    chk(log_n == 1, "R1", "writes after deselected clocks", log_n, 1);
    chk(log_addr[0] == 5 && log_data[0] == 8'h5A, "R2", "addr/data after idle clocks",
        log_addr[0] * 256 + log_data[0], 5 * 256 + 8'h5A);

    // R5: partial byte discarded by a new select fall
    log_n = 0;
    start_xfer(); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    tick(4); cs_n = 1'b1; tick(8);
    start_xfer(); send_byte(8'h10); send_byte(8'hC3); stop_xfer();
    chk(log_n == 1, "R5", "writes after aborted byte", log_n, 1);
    chk(log_addr[0] == 16 && log_data[0] == 8'hC3, "R5", "addr/data after abort",
        log_addr[0] * 256 + log_data[0], 16 * 256 + 8'hC3);

    // R4: strobe latency after the eighth rising edge, no extra input
    log_n = 0;
    start_xfer(); send_byte(8'h60);
    begin
      logic [7:0] b; int lat; b = 8'hB4; lat = -1;
      for (int i = 0; i < 7; i++) send_bit(b[i]);
      sdata = b[7]; tick(5); sclk = 1'b1;
      for (int c = 1; c <= 14; c++) begin
        @(negedge clk);
        if (ram_we && lat < 0) lat = c;
      end
      chk(lat > 0 && lat <= 10, "R4", "strobe latency cycles", lat, 10);
      sclk = 1'b0;
    end
    stop_xfer();
    chk(log_n == 1 && log_sel[0] == 3 && log_data[0] == 8'hB4, "R4", "auto write content",
        log_data[0], 8'hB4);

    chk(pulse_err == 0, "R10", "multi-cycle strobes", pulse_err, 0);
    chk(both_err == 0, "R10", "both strobes high", both_err, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule